// File: doc/BRIEF.md
# Triggered Pattern Playback Sequencer

The block replays a sample vector held in on-chip storage to a converter data port, issuing one sample on each cycle of a data clock that arrives from outside the block. A host fills the storage through a plain write port, then programs the vector length, whether playback repeats forever or a set number of times, the repeat count, and how the trigger pin is used.

Playback begins on a software start command. If the trigger is enabled as an input, a start command only arms the sequencer, and the first rising edge of the external trigger launches playback. If the trigger is enabled as an output, the block raises a one-cycle marker together with the first sample of every pass through the vector. A stop command returns the sequencer to idle at any time. Lengths that are shorter than one 64-sample block, that are not a whole number of blocks, or that exceed the storage are refused.

Top module: `pattern_player`

## Requirements
- R1: A configuration write with a length below 64, a length that is not a multiple of 64, or a length above the storage depth (256 by default) raises `cfg_err`. While `cfg_err` is high, neither a start command nor a trigger edge starts playback. After reset the length is 64 and `cfg_err` is low.
- R2: With the trigger not used as an input (`cfg_trig_en`=0, or `cfg_trig_dir`=1), a start command sampled on a clock edge makes `smp_valid` high and `smp_data` equal to stored word 0 just after that same edge. Word k follows on each later cycle with no gap.
- R3: With `cfg_trig_en`=1 and `cfg_trig_dir`=0, a start command only arms the block. `trig_in` passes through a two-flop synchronizer, and playback begins only on a low-to-high transition seen while armed. Word 0 appears just after the third clock edge that follows the rise of `trig_in`. A level that is already high when the block is armed does not start it.
- R4: With `cfg_trig_en`=1 and `cfg_trig_dir`=1, `trig_out` is high for exactly the cycles in which `smp_data` carries word 0 with `smp_valid` high. In every other setting, `trig_out` stays low.
- R5: In loop mode (`cfg_loop`=1), word length-1 is followed directly by word 0, with no idle cycle, until a stop command.
- R6: In count mode (`cfg_loop`=0), the vector plays exactly `cfg_reps` times, with a count of 0 treated as 1. On the cycle after the last word, `smp_valid` is low and `done` is high.
- R7: `cmd_stop` has priority over every other input. On the cycle after it is sampled, `smp_valid` and `done` are low and the block is idle from any state, including armed.
- R8: While `smp_valid` is low, `smp_data` holds the last word driven, or zero after reset.
- R9: Configuration writes issued while playback runs are ignored. Length, mode, count, trigger setting and `cfg_err` all keep their values.
- R10: After reset, `smp_valid`, `trig_out`, `done`, `cfg_err` and `smp_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock supplied from outside the block |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the sample storage |
| wr_addr | input | ADDR_W | Storage word address |
| wr_data | input | SAMPLE_W | Word to store |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | ADDR_W+1 | Vector length in samples |
| cfg_loop | input | 1 | 1 = loop forever, 0 = count mode |
| cfg_reps | input | CNT_W | Pass count for count mode |
| cfg_trig_en | input | 1 | Trigger pin in use |
| cfg_trig_dir | input | 1 | 0 = trigger is an input, 1 = trigger is an output marker |
| cmd_start | input | 1 | Start (or arm) command |
| cmd_stop | input | 1 | Stop command |
| trig_in | input | 1 | External trigger, asynchronous |
| smp_data | output | SAMPLE_W | Sample to the converter |
| smp_valid | output | 1 | High while samples are being issued |
| trig_out | output | 1 | Start-of-pass marker |
| cfg_err | output | 1 | Last accepted length was illegal |
| done | output | 1 | Count mode has finished |

## Verification
A read pointer that skips or repeats shows up as a wrong word on `smp_data` in the very next cycle. A wrong wrap point shows as a marker pulse at the wrong position in the pass. A pass counter that is off by one moves the fall of `smp_valid` by a whole vector length, which the count-mode sweep catches at the end of the run. A frozen configuration that leaks, or a missed edge in the trigger synchronizer, changes the pass period or the start cycle. Because the bench compares every output cycle against arithmetic expectations, either fault is seen within one vector length.

// File: rtl/pattern_player_pkg.sv
package pattern_player_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  // legal length: whole blocks, at least one, within capacity
  function automatic logic length_ok(int unsigned len, int unsigned blk, int unsigned cap);
    return (len >= blk) && ((len % blk) == 0) && (len <= cap);
  endfunction

  // index that follows idx in a vector of len words
  function automatic int unsigned step_index(int unsigned idx, int unsigned len);
    return (idx + 1 >= len) ? 0 : idx + 1;
  endfunction

  // number of passes played for a programmed count
  function automatic int unsigned pass_target(int unsigned reps);
    return (reps == 0) ? 1 : reps;
  endfunction

endpackage

// File: rtl/pp_trig_sync.sv
module pp_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise
);
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], trig_in};
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign rise = sh_q[1] & ~sh_q[2];

  AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3

endmodule

// File: rtl/pp_sample_store.sv
module pp_sample_store #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                emit,
  output logic [SAMPLE_W-1:0] smp_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [SAMPLE_W-1:0] pf_q;
  logic [SAMPLE_W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // prefetch register always holds the word to issue next
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_q  <= '0;
      out_q <= '0;
    end else begin
      pf_q <= mem[rd_addr];
      if (emit) out_q <= pf_q;
    end
  end

  assign smp_data = out_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> $stable(smp_data)); // R8

endmodule

// File: rtl/pp_seq_ctrl.sv
module pp_seq_ctrl
  import pattern_player_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int BLOCK  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W:0]   cfg_len,
  input  logic              cfg_loop,
  input  logic [CNT_W-1:0]  cfg_reps,
  input  logic              cfg_trig_en,
  input  logic              cfg_trig_dir,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              trig_rise,
  output logic              emit,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              smp_valid,
  output logic              trig_out,
  output logic              cfg_err,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LEN_W = ADDR_W + 1;

  seq_state_e        state, state_nx;
  logic [LEN_W-1:0]  len_q;
  logic              loop_q, tren_q, trdir_q, err_q, mark_q;
  logic [CNT_W-1:0]  reps_q, pass_cnt;
  logic [ADDR_W-1:0] pf_idx, out_idx;

  // named events for the assertions
  logic idle_like, wait_trig, go_now, at_last, finish, cfg_take, arm_now;

  always_comb begin
    idle_like = (state == ST_IDLE) || (state == ST_DONE);
    wait_trig = tren_q && !trdir_q;
    go_now    = !err_q && (((state == ST_ARMED) && trig_rise) ||
                           (idle_like && cmd_start && !wait_trig));
    arm_now   = !err_q && idle_like && cmd_start && wait_trig;
    at_last   = (32'(out_idx) + 1) == 32'(len_q);
    finish    = (state == ST_RUN) && at_last && !loop_q &&
                ((32'(pass_cnt) + 1) >= pass_target(32'(reps_q)));
    emit      = !cmd_stop && (go_now || ((state == ST_RUN) && !finish));
    rd_addr   = emit ? ADDR_W'(step_index(32'(pf_idx), 32'(len_q))) : '0;
    cfg_take  = cfg_we && (state != ST_RUN);

    state_nx = state;
    if (cmd_stop)    state_nx = ST_IDLE;
    else if (go_now) state_nx = ST_RUN;
    else if (finish) state_nx = ST_DONE;
    else if (arm_now) state_nx = ST_ARMED;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      len_q    <= LEN_W'(BLOCK);
      loop_q   <= 1'b0;
      reps_q   <= CNT_W'(1);
      tren_q   <= 1'b0;
      trdir_q  <= 1'b0;
      err_q    <= 1'b0;
      pf_idx   <= '0;
      out_idx  <= '0;
      pass_cnt <= '0;
      mark_q   <= 1'b0;
    end else begin
      state  <= state_nx;
      pf_idx <= rd_addr;
      if (cfg_take) begin
        len_q   <= cfg_len;
        loop_q  <= cfg_loop;
        reps_q  <= cfg_reps;
        tren_q  <= cfg_trig_en;
        trdir_q <= cfg_trig_dir;
        err_q   <= !length_ok(32'(cfg_len), BLOCK, DEPTH);
      end
      if (emit) out_idx <= pf_idx;
      if (go_now)
        pass_cnt <= '0;
      else if (emit && (state == ST_RUN) && at_last && !loop_q)
        pass_cnt <= pass_cnt + 1'b1;
      mark_q <= emit && (pf_idx == '0) && tren_q && trdir_q;
    end
  end

  assign smp_valid = (state == ST_RUN);
  assign trig_out  = mark_q;
  assign cfg_err   = err_q;
  assign done      = (state == ST_DONE);

  AST_BAD_LEN_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != ST_RUN) && cfg_err) |=> (state != ST_RUN)); // R1

  AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (go_now && !cmd_stop) |=> (smp_valid && (out_idx == '0))); // R2

  AST_MARK_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> (smp_valid && (out_idx == '0))); // R4

  AST_STEP_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RUN) && emit) |=>
      (out_idx == ADDR_W'(step_index(32'($past(out_idx)), 32'($past(len_q)))))); // R5

  AST_PASS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DONE) && ($past(state) == ST_RUN)) |->
      ((32'(pass_cnt) + 1) == pass_target(32'(reps_q)))); // R6

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (state == ST_IDLE)); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> ($stable(len_q) && $stable(loop_q) && $stable(err_q))); // R9

endmodule

// File: rtl/pattern_player.sv
module pattern_player #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 8,
  parameter int BLOCK    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                cfg_we,
  input  logic [ADDR_W:0]     cfg_len,
  input  logic                cfg_loop,
  input  logic [CNT_W-1:0]    cfg_reps,
  input  logic                cfg_trig_en,
  input  logic                cfg_trig_dir,
  input  logic                cmd_start,
  input  logic                cmd_stop,
  input  logic                trig_in,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_valid,
  output logic                trig_out,
  output logic                cfg_err,
  output logic                done
);
  logic              trig_rise;
  logic              emit;
  logic [ADDR_W-1:0] rd_addr;

  pp_trig_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .rise    (trig_rise)
  );

  pp_seq_ctrl #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .BLOCK  (BLOCK)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_len      (cfg_len),
    .cfg_loop     (cfg_loop),
    .cfg_reps     (cfg_reps),
    .cfg_trig_en  (cfg_trig_en),
    .cfg_trig_dir (cfg_trig_dir),
    .cmd_start    (cmd_start),
    .cmd_stop     (cmd_stop),
    .trig_rise    (trig_rise),
    .emit         (emit),
    .rd_addr      (rd_addr),
    .smp_valid    (smp_valid),
    .trig_out     (trig_out),
    .cfg_err      (cfg_err),
    .done         (done)
  );

  pp_sample_store #(
    .SAMPLE_W (SAMPLE_W),
    .ADDR_W   (ADDR_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .emit     (emit),
    .smp_data (smp_data)
  );

  AST_VALID_WITH_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !smp_valid) |=> smp_valid); // R2

endmodule

// File: tb/test_pattern_player.sv
module test_pattern_player;
  localparam int SW = 16;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [SW-1:0] wr_data = '0;
  logic          cfg_we = 1'b0;
  logic [AW:0]   cfg_len = '0;
  logic          cfg_loop = 1'b0;
  logic [CW-1:0] cfg_reps = '0;
  logic          cfg_trig_en = 1'b0;
  logic          cfg_trig_dir = 1'b0;
  logic          cmd_start = 1'b0;
  logic          cmd_stop = 1'b0;
  logic          trig_in = 1'b0;
  logic [SW-1:0] smp_data;
  logic          smp_valid, trig_out, cfg_err, done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pattern_player #(.SAMPLE_W(SW), .ADDR_W(AW), .CNT_W(CW), .BLOCK(64)) i_pattern_player (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_loop(cfg_loop), .cfg_reps(cfg_reps),
    .cfg_trig_en(cfg_trig_en), .cfg_trig_dir(cfg_trig_dir),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .trig_in(trig_in),
    .smp_data(smp_data), .smp_valid(smp_valid), .trig_out(trig_out),
    .cfg_err(cfg_err), .done(done)
  );

  function automatic logic [SW-1:0] pat(int i);
    return SW'(i * 401 + 17);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic set_cfg(int len, bit lp, int reps, bit ten, bit tdir);
    @(negedge clk);
    cfg_we = 1'b1; cfg_len = (AW+1)'(len); cfg_loop = lp;
    cfg_reps = CW'(reps); cfg_trig_en = ten; cfg_trig_dir = tdir;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  // count-mode run with every output cycle compared
  task automatic run_count(int len, int reps, bit mark);
    int n;
    set_cfg(len, 1'b0, reps, mark, 1'b1);
    chk(cfg_err == 1'b0, "R1", "legal length flagged", cfg_err, 0);
    n = ((reps == 0) ? 1 : reps) * len;
    pulse_start();
    for (int k = 0; k < n; k++) begin
      chk(smp_valid && smp_data == pat(k % len), "R2", "sample word", smp_data, pat(k % len));
      chk(trig_out == (mark && (k % len == 0)), "R4", "marker", trig_out, mark && (k % len == 0));
      @(negedge clk);
    end
    chk(!smp_valid && done, "R6", "end of count (valid,done)", {smp_valid, done}, 1);
    chk(smp_data == pat(len - 1), "R8", "held word", smp_data, pat(len - 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!smp_valid && !trig_out && !done && !cfg_err, "R10", "reset flags",
        {smp_valid, trig_out, done, cfg_err}, 0);
    chk(smp_data == '0, "R10", "reset data", smp_data, 0);

    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(i);
    end
    @(negedge clk); wr_en = 1'b0;

    // R1 illegal lengths refused
    begin
      int bad [7] = '{0, 32, 63, 65, 100, 320, 511};
      foreach (bad[j]) begin
        set_cfg(bad[j], 1'b0, 1, 1'b0, 1'b0);
        chk(cfg_err == 1'b1, "R1", "illegal length flag", cfg_err, 1);
        pulse_start();
        repeat (3) begin
          chk(!smp_valid, "R1", "start refused", smp_valid, 0);
          @(negedge clk);
        end
      end
    end

    // R6 sweep of lengths and counts
    for (int l = 1; l <= 4; l++)
      for (int r = 1; r <= 3; r++)
        run_count(64 * l, r, (r != 2));
    run_count(64, 0, 1'b1);

    // R5 loop mode, R9 config ignored while running, R7 stop
    set_cfg(64, 1'b1, 1, 1'b1, 1'b1);
    pulse_start();
    for (int k = 0; k < 300; k++) begin
      chk(smp_valid && smp_data == pat(k % 64), "R5", "loop word", smp_data, pat(k % 64));
      chk(trig_out == (k % 64 == 0), "R4", "loop marker", trig_out, k % 64 == 0);
      if (k == 100) begin
        cfg_we = 1'b1; cfg_len = 9'd100; cfg_loop = 1'b0; cfg_reps = 8'd1; cfg_trig_en = 1'b0;
      end
      if (k == 101) cfg_we = 1'b0;
      if (k == 299) cmd_stop = 1'b1;
      @(negedge clk);
    end
    cmd_stop = 1'b0;
    chk(!smp_valid && !done, "R7", "stop from running", {smp_valid, done}, 0);
    chk(cfg_err == 1'b0, "R9", "error flag kept", cfg_err, 0);
    repeat (4) begin
      chk(smp_data == pat(299 % 64), "R8", "hold after stop", smp_data, pat(299 % 64));
      @(negedge clk);
    end
    pulse_start();
    for (int k = 0; k < 70; k++) begin
      chk(smp_valid && smp_data == pat(k % 64), "R9", "old length kept", smp_data, pat(k % 64));
      chk(trig_out == (k % 64 == 0), "R9", "old trigger mode kept", trig_out, k % 64 == 0);
      if (k == 69) cmd_stop = 1'b1;
      @(negedge clk);
    end
    cmd_stop = 1'b0;

    // R3 trigger input start
    set_cfg(64, 1'b0, 1, 1'b1, 1'b0);
    trig_in = 1'b1;
    repeat (4) @(negedge clk);
    pulse_start();
    repeat (8) begin
      chk(!smp_valid, "R3", "high level does not start", smp_valid, 0);
      @(negedge clk);
    end
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
    trig_in = 1'b1;
    @(negedge clk);
    chk(!smp_valid, "R3", "no start after 1 edge", smp_valid, 0);
    @(negedge clk);
    chk(!smp_valid, "R3", "no start after 2 edges", smp_valid, 0);
    @(negedge clk);
    for (int k = 0; k < 64; k++) begin
      chk(smp_valid && smp_data == pat(k), "R3", "triggered word", smp_data, pat(k));
      chk(!trig_out, "R4", "no marker in input mode", trig_out, 0);
      @(negedge clk);
    end
    chk(!smp_valid && done, "R6", "triggered single pass end", {smp_valid, done}, 1);

    // R7 stop while armed
    trig_in = 1'b0;
    pulse_start();
    @(negedge clk); cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
    chk(!done && !smp_valid, "R7", "stop from armed", {smp_valid, done}, 0);
    trig_in = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(!smp_valid, "R7", "edge after stop ignored", smp_valid, 0);
    end
    trig_in = 1'b0;

    finish_run();
  end

endmodule